// File: doc/BRIEF.md
# Third-Order Fractional-N Modulus Sequencer

This block feeds a programmable feedback divider in a fractional-N loop. Each time the reference-rate enable is raised, it produces one integer divide value. Over the long run the mean of these values equals INT + FRAC/MOD. The fraction comes from three first-order accumulators in cascade. Each accumulator wraps at a programmable modulus of up to 4095, which does not have to be a power of two. The three carry streams are combined through first and second differences, so the quantization error is pushed toward high offsets with a third-order shape.

A load strobe captures INT, FRAC and MOD and returns every accumulator and carry delay to zero. From then on the sequence is fully determined by the loaded values. Each accepted step makes a registered divide value appear one clock later, together with a one-cycle valid strobe. The divider that consumes the value is not part of this block.

Top module: `mash_frac_seq`

## Requirements
- R1: After synchronous reset, `div_valid_o` is 0 and `div_o` is 0.
- R2: A step is accepted when `ref_en_i` is 1 and `load_i` is 0. `div_valid_o` is 1 in exactly the cycle that follows an accepted step and is 0 in every other cycle.
- R3: With a loaded FRAC of 0, every produced value equals INT.
- R4: Every produced value lies between INT-3 and INT+4, both included.
- R5: Let S be the sum of the first n values after a load, and let F = floor(n*FRAC/MOD). Then S - n*INT lies between F-1 and F+2.
- R6: A load clears all accumulator and delay state. Loading identical values again restarts the identical sequence.
- R7: Changes on `int_i`, `frac_i` and `mod_i` while `load_i` is 0 have no effect on the produced values.
- R8: In a cycle without an accepted step, the state is held. `div_o` keeps its value, and the sequence continues afterwards as if no pause had occurred.
- R9: With FRAC equal to MOD, every produced value equals INT+1.
- R10: Each of the three stages computes acc+in. When that sum is greater than or equal to MOD, the stage subtracts MOD and sets its carry. Stage 1 adds FRAC, stage 2 adds the new stage 1 residue, and stage 3 adds the new stage 2 residue. The value produced is INT + c1 + (c2 - c2') + (c3 - 2c3' + c3''), where ' marks one step earlier and '' two steps earlier. Carries before the load count as 0.
- R11: The sequence is correct at the modulus extremes MOD=2 and MOD=4095, and for a modulus that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en_i | input | 1 | Reference-rate step enable |
| load_i | input | 1 | Capture configuration and clear state |
| int_i | input | INT_W | Integer part, valid 31..255 |
| frac_i | input | MOD_W | Fraction numerator, valid 0..MOD |
| mod_i | input | MOD_W | Modulus, valid 2..4095 |
| div_o | output | INT_W+1 | Divide value for the feedback counter |
| div_valid_o | output | 1 | One-cycle strobe for a new `div_o` |

## Verification
A wrong residue in any stage changes its carry stream within a few steps. It then shows at `div_o` as a value that differs from the exact step-by-step model, often before it leaves the INT-3..INT+4 window. A stale delay register shows up within two steps of a load as a nonzero offset where FRAC=0 or FRAC=MOD demands a flat output. A drift in the mean becomes visible in the running sum against floor(n*FRAC/MOD) over a few hundred steps.

// File: rtl/mash_seq_pkg.sv
package mash_seq_pkg;
  localparam int ORDER        = 3;
  localparam int DEF_INT_W    = 8;
  localparam int DEF_MOD_W    = 12;
  localparam int MAX_UP_OFS   = 4;
  localparam int MAX_DOWN_OFS = 3;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [MOD_W-1:0] add_i,
  output logic [MOD_W-1:0] res_o,
  output logic             carry_o
);
  localparam int SUM_W = MOD_W + 1;

  logic [MOD_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, add_i};
    wrapped = sum - {1'b0, mod_i};
    carry_o = (sum >= {1'b0, mod_i});
    res_o   = carry_o ? wrapped[MOD_W-1:0] : sum[MOD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (step)  acc_q <= res_o;
  end
endmodule

// File: rtl/mash_combiner.sv
module mash_combiner #(
  parameter int INT_W = 8,
  parameter int ORDER = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [INT_W-1:0] int_i,
  input  logic [ORDER-1:0] carry_i,
  output logic [INT_W:0]   div_o,
  output logic             valid_o
);
  localparam int OUT_W = INT_W + 1;

  logic             c2_d, c3_d, c3_dd;
  logic [OUT_W-1:0] nxt;

  always_comb begin
    nxt = {1'b0, int_i}
        + OUT_W'(carry_i[0])
        + OUT_W'(carry_i[1]) - OUT_W'(c2_d)
        + OUT_W'(carry_i[2]) + OUT_W'(c3_dd) - (OUT_W'(c3_d) << 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (step) begin
      c2_d  <= carry_i[1];
      c3_dd <= c3_d;
      c3_d  <= carry_i[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= step;
      if (step) div_o <= nxt;
    end
  end
endmodule

// File: rtl/mash_frac_seq.sv
module mash_frac_seq #(
  parameter int INT_W = mash_seq_pkg::DEF_INT_W,
  parameter int MOD_W = mash_seq_pkg::DEF_MOD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en_i,
  input  logic             load_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [INT_W:0]   div_o,
  output logic             div_valid_o
);
  import mash_seq_pkg::*;

  logic [INT_W-1:0] cfg_int;
  logic [MOD_W-1:0] cfg_frac;
  logic [MOD_W-1:0] cfg_mod;
  logic             step;

  logic [MOD_W-1:0] stage_in  [ORDER];
  logic [MOD_W-1:0] stage_res [ORDER];
  logic [ORDER-1:0] carry;

  assign step = ref_en_i & ~load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_int  <= '0;
      cfg_frac <= '0;
      cfg_mod  <= '0;
    end else if (load_i) begin
      cfg_int  <= int_i;
      cfg_frac <= frac_i;
      cfg_mod  <= mod_i;
    end
  end

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_in[g] = cfg_frac;
    end else begin : g_tail
      assign stage_in[g] = stage_res[g-1];
    end

    mash_acc_stage #(.MOD_W(MOD_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .clr    (load_i),
      .step   (step),
      .mod_i  (cfg_mod),
      .add_i  (stage_in[g]),
      .res_o  (stage_res[g]),
      .carry_o(carry[g])
    );
  end

  mash_combiner #(.INT_W(INT_W), .ORDER(ORDER)) u_comb (
    .clk    (clk),
    .rst    (rst),
    .clr    (load_i),
    .step   (step),
    .int_i  (cfg_int),
    .carry_i(carry),
    .div_o  (div_o),
    .valid_o(div_valid_o)
  );
endmodule

// File: rtl/mash_frac_seq_chk.sv
module mash_frac_seq_chk #(
  parameter int INT_W = 8,
  parameter int MOD_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_en_i,
  input logic             load_i,
  input logic [INT_W-1:0] cfg_int,
  input logic [MOD_W-1:0] cfg_frac,
  input logic [MOD_W-1:0] cfg_mod,
  input logic [INT_W:0]   div_o,
  input logic             div_valid_o
);
  localparam int OUT_W = INT_W + 1;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !div_valid_o);

  // R2
  valid_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_en_i && !load_i) |=> div_valid_o);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(ref_en_i && !load_i) |=> !div_valid_o);

  // R3
  flat_on_zero_frac_chk: assert property (@(posedge clk) disable iff (rst)
    (div_valid_o && cfg_frac == '0) |-> div_o == OUT_W'(cfg_int));

  // R4
  window_chk: assert property (@(posedge clk) disable iff (rst)
    div_valid_o |-> ((div_o + OUT_W'(3) >= OUT_W'(cfg_int)) &&
                     (div_o <= OUT_W'(cfg_int) + OUT_W'(4))));

  // R9
  full_frac_chk: assert property (@(posedge clk) disable iff (rst)
    (div_valid_o && cfg_frac == cfg_mod) |-> div_o == OUT_W'(cfg_int) + OUT_W'(1));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !div_valid_o |-> $stable(div_o) || $past(rst));
endmodule

bind mash_frac_seq mash_frac_seq_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ref_en_i   (ref_en_i),
  .load_i     (load_i),
  .cfg_int    (cfg_int),
  .cfg_frac   (cfg_frac),
  .cfg_mod    (cfg_mod),
  .div_o      (div_o),
  .div_valid_o(div_valid_o)
);

// File: tb/mash_frac_seq_tb.sv
`timescale 1ns/1ps
module mash_frac_seq_tb;
  localparam int INT_W = 8;
  localparam int MOD_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ref_en_i = 1'b0;
  logic             load_i = 1'b0;
  logic [INT_W-1:0] int_i = '0;
  logic [MOD_W-1:0] frac_i = '0;
  logic [MOD_W-1:0] mod_i = '0;
  logic [INT_W:0]   div_o;
  logic             div_valid_o;

  always #2.5 clk = ~clk;

  mash_frac_seq #(.INT_W(INT_W), .MOD_W(MOD_W)) u_dut (
    .clk(clk), .rst(rst), .ref_en_i(ref_en_i), .load_i(load_i),
    .int_i(int_i), .frac_i(frac_i), .mod_i(mod_i),
    .div_o(div_o), .div_valid_o(div_valid_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int m_int, m_frac, m_mod;
  int a1, a2, a3, c2p, c3p, c3pp;
  longint n_steps, sum_out;
  int last_div;

  function automatic int acc_carry(int acc, int add, int md);
    return ((acc + add) >= md) ? 1 : 0;
  endfunction

  function automatic int acc_res(int acc, int add, int md);
    return ((acc + add) >= md) ? (acc + add - md) : (acc + add);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic model_clear();
    a1 = 0; a2 = 0; a3 = 0; c2p = 0; c3p = 0; c3pp = 0;
    n_steps = 0; sum_out = 0;
  endtask

  task automatic model_step(output int exp);
    int c1, c2, c3;
    c1 = acc_carry(a1, m_frac, m_mod); a1 = acc_res(a1, m_frac, m_mod);
    c2 = acc_carry(a2, a1, m_mod);     a2 = acc_res(a2, a1, m_mod);
    c3 = acc_carry(a3, a2, m_mod);     a3 = acc_res(a3, a2, m_mod);
    exp = m_int + c1 + c2 - c2p + c3 - 2 * c3p + c3pp;
    c3pp = c3p; c3p = c3; c2p = c2;
  endtask

  // load at a negedge; checks valid is low the following cycle (R2, R6)
  task automatic do_load(int vi, int vf, int vm);
    int_i = INT_W'(vi); frac_i = MOD_W'(vf); mod_i = MOD_W'(vm);
    load_i = 1'b1; ref_en_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; ref_en_i = 1'b0;
    check(div_valid_o == 1'b0, "R2 no valid on load cycle", div_valid_o, 0);
    m_int = vi; m_frac = vf; m_mod = vm;
    model_clear();
  endtask

  task automatic run(int n, int pct, string tag);
    for (int i = 0; i < n; i++) begin
      bit en;
      int exp;
      longint fl, dev;
      en = (($urandom % 100) < pct);
      ref_en_i = en;
      @(negedge clk);
      ref_en_i = 1'b0;
      if (en) begin
        model_step(exp);
        check(div_valid_o == 1'b1, "R2 valid after step", div_valid_o, 1);
        check(int'(div_o) == exp, {"R10 sequence ", tag}, div_o, exp);
        check(int'(div_o) >= m_int - 3 && int'(div_o) <= m_int + 4,
              "R4 window", div_o, m_int);
        if (m_frac == 0)     check(int'(div_o) == m_int, "R3 flat", div_o, m_int);
        if (m_frac == m_mod) check(int'(div_o) == m_int + 1, "R9 full", div_o, m_int + 1);
        n_steps++;
        sum_out += div_o;
        fl  = (n_steps * m_frac) / m_mod;
        dev = sum_out - n_steps * m_int;
        check(dev >= fl - 1 && dev <= fl + 2, "R5 running mean", dev, fl);
        last_div = div_o;
      end else begin
        check(div_valid_o == 1'b0, "R2 no valid idle", div_valid_o, 0);
        check(int'(div_o) == last_div, "R8 hold", div_o, last_div);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    last_div = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(div_valid_o == 1'b0, "R1 reset valid", div_valid_o, 0);
    check(div_o == '0, "R1 reset div", div_o, 0);

    do_load(100, 0, 7);        run(20, 100, "frac0");
    do_load(31, 5, 5);         run(20, 100, "full");
    do_load(255, 4095, 4095);  run(10, 100, "full max");
    do_load(50, 1, 2);         run(40, 100, "R11 mod2");
    do_load(200, 4094, 4095);  run(300, 100, "R11 mod4095");
    do_load(77, 333, 1000);    run(200, 100, "R11 non-pow2");

    // R6: reload identical values mid-run, sequence restarts from clear state
    do_load(40, 3, 10);        run(23, 100, "R6 first");
    do_load(40, 3, 10);        run(30, 100, "R6 restart");

    // R7: input changes without load are ignored
    do_load(60, 17, 101);
    int_i = 8'd200; frac_i = 12'd5; mod_i = 12'd9;
    run(60, 100, "R7 inputs ignored");

    // R8: gaps in the enable
    do_load(90, 123, 777);     run(400, 40, "R8 gaps");

    for (int k = 0; k < 10; k++) begin
      int vi, vm, vf;
      vi = 31 + ($urandom % 225);
      vm = 2 + ($urandom % 4094);
      vf = $urandom % (vm + 1);
      do_load(vi, vf, vm);
      run(300, 75, "random");
    end
    finish_run();
  end
endmodule